// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and a full calendar. Every field is packed BCD: seconds, minutes, hours in 24-hour form, day of week, date, month, two-digit year and century. A single-cycle tick pulse, one per second and synchronous to the system clock, moves the whole time forward by one second. The carries run through the fields in order, as far as the century.

Software sets the time with one load strobe, which writes all eight fields from a parallel bus in one cycle. All fields are visible on parallel outputs at all times. The last date of each month is chosen from the month and year. Leap years use the plain divisible-by-four test on the two-digit year, which holds up to the year 2100.

Top module: `bcd_calendar_counter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the outputs read century 20, year 00, month 01, date 01, day of week 1 and time 00:00:00.
- R2: With neither tick nor load asserted, no output field changes.
- R3: Each field is packed BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0]. A tick raises seconds by one in BCD, so a units digit of 9 goes to 0 and the tens digit goes up by one (09 becomes 10).
- R4: Seconds wrap from 59 to 00 and advance minutes on the same tick. Minutes wrap from 59 to 00 and advance hours.
- R5: Hours wrap from 23 to 00 and advance both date and day of week. Day of week counts 1 to 7 and goes from 7 back to 1.
- R6: The last date is 30 in months 04, 06, 09 and 11, and 31 in months 01, 03, 05, 07, 08, 10 and 12. February ends on 28, or on 29 in a leap year. Past the last date, date goes to 01 and month advances.
- R7: A leap year is a two-digit year divisible by four, with 00 included.
- R8: Month wraps from 12 to 01 and advances year. Year wraps from 99 to 00 and advances the century.
- R9: An asserted load writes every field from the load inputs on the next clock edge. It takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle pulse, one second elapsed |
| load | input | 1 | Write all fields from the load inputs |
| ld_sec | input | 8 | Seconds to load, BCD |
| ld_min | input | 8 | Minutes to load, BCD |
| ld_hour | input | 8 | Hours to load, BCD |
| ld_dow | input | 8 | Day of week to load, BCD 1..7 |
| ld_date | input | 8 | Date to load, BCD |
| ld_month | input | 8 | Month to load, BCD |
| ld_year | input | 8 | Two-digit year to load, BCD |
| ld_cent | input | 8 | Century to load, BCD |
| q_sec | output | 8 | Current seconds |
| q_min | output | 8 | Current minutes |
| q_hour | output | 8 | Current hours |
| q_dow | output | 8 | Current day of week |
| q_date | output | 8 | Current date |
| q_month | output | 8 | Current month |
| q_year | output | 8 | Current two-digit year |
| q_cent | output | 8 | Current century |

## Verification
The bench loads the time one second before each month end and then ticks once. It covers every 30-day month, several 31-day months, and February in common years, in leap years and in year 00. A wrong length table would either skip a real date or show a date such as 04/31. It crosses the units-digit boundary of 09 to 10, which a binary incrementer would turn into 0A. It loads New Year's Eve of year 99 to check that the carry reaches the century, and that day of week goes from 7 back to 1 and not to 8 or 0. It also asserts load and tick together, where a design with the wrong priority would show the loaded time plus one second.

// File: rtl/bcd_cal_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants for the BCD calendar counter.
// Assumes two-digit packed BCD fields, tens in the upper nibble.
package bcd_cal_pkg;
    localparam int unsigned DIGIT_W  = 4;
    localparam int unsigned FIELD_W  = 2 * DIGIT_W;
    localparam int unsigned N_FIELDS = 8;

    typedef logic [FIELD_W-1:0] bcd2_t;

    // Field index order: the carry chain runs from low to high index.
    localparam int unsigned F_SEC  = 0;
    localparam int unsigned F_MIN  = 1;
    localparam int unsigned F_HOUR = 2;
    localparam int unsigned F_DOW  = 3;
    localparam int unsigned F_DATE = 4;
    localparam int unsigned F_MON  = 5;
    localparam int unsigned F_YEAR = 6;
    localparam int unsigned F_CENT = 7;

    // Highest value of each field (the date entry is replaced at run time).
    localparam bcd2_t LAST_C  [N_FIELDS] = '{8'h59, 8'h59, 8'h23, 8'h07,
                                             8'h31, 8'h12, 8'h99, 8'h99};
    // Value each field wraps back to.
    localparam bcd2_t FIRST_C [N_FIELDS] = '{8'h00, 8'h00, 8'h00, 8'h01,
                                             8'h01, 8'h01, 8'h00, 8'h00};
    // Value each field takes in reset.
    localparam bcd2_t INIT_C  [N_FIELDS] = '{8'h00, 8'h00, 8'h00, 8'h01,
                                             8'h01, 8'h01, 8'h00, 8'h20};
endpackage

// File: rtl/bcd_step.sv
`timescale 1ns/1ps
// Module: bcd_step
// Works out the next value of one two-digit BCD field and flags a wrap.
// Assumes the input is valid BCD. A value at or above the limit wraps to
// the first value, so a loaded value past the limit recovers on the next step.
module bcd_step
    import bcd_cal_pkg::*;
(
    input  bcd2_t cur,
    input  bcd2_t last,
    input  bcd2_t first,
    output bcd2_t nxt,
    output logic  wrap
);
    logic [DIGIT_W-1:0] tens;
    logic [DIGIT_W-1:0] units;

    assign tens  = cur[FIELD_W-1:DIGIT_W];
    assign units = cur[DIGIT_W-1:0];

    // Decimal increment with a units-to-tens carry, or wrap at the limit.
    always_comb begin
        wrap = (cur >= last);
        if (wrap) begin
            nxt = first;
        end else if (units >= DIGIT_W'(9)) begin
            nxt = {tens + DIGIT_W'(1), {DIGIT_W{1'b0}}};
        end else begin
            nxt = {tens, units + DIGIT_W'(1)};
        end
    end
endmodule

// File: rtl/bcd_month_len.sv
`timescale 1ns/1ps
// Module: bcd_month_len
// Gives the last date of a month, in BCD, from the BCD month and year.
// Assumes a leap year is any two-digit year divisible by four.
module bcd_month_len
    import bcd_cal_pkg::*;
(
    input  bcd2_t month,
    input  bcd2_t year,
    output bcd2_t last_date
);
    logic [DIGIT_W-1:0] yr_t;
    logic [DIGIT_W-1:0] yr_u;
    logic               leap;

    assign yr_t = year[FIELD_W-1:DIGIT_W];
    assign yr_u = year[DIGIT_W-1:0];

    // Divisible by four: even tens with units 0/4/8, or odd tens with 2/6.
    always_comb begin
        if (yr_t[0]) leap = (yr_u == 4'd2) || (yr_u == 4'd6);
        else         leap = (yr_u == 4'd0) || (yr_u == 4'd4) || (yr_u == 4'd8);
    end

    // Pick the month length.
    always_comb begin
        unique case (month)
            8'h02:                      last_date = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end
endmodule

// File: rtl/bcd_calendar_counter.sv
`timescale 1ns/1ps
// Module: bcd_calendar_counter
// Keeps seconds through century in packed BCD and advances one second per
// tick. It applies a full-field load, which wins over the tick.
// Assumes tick is a one-cycle enable in the clk domain. Reset is synchronous
// and active low.
module bcd_calendar_counter
    import bcd_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       load,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [7:0] ld_dow,
    input  logic [7:0] ld_date,
    input  logic [7:0] ld_month,
    input  logic [7:0] ld_year,
    input  logic [7:0] ld_cent,
    output logic [7:0] q_sec,
    output logic [7:0] q_min,
    output logic [7:0] q_hour,
    output logic [7:0] q_dow,
    output logic [7:0] q_date,
    output logic [7:0] q_month,
    output logic [7:0] q_year,
    output logic [7:0] q_cent
);
    bcd2_t fld     [N_FIELDS];
    bcd2_t ld_v    [N_FIELDS];
    bcd2_t nxt_v   [N_FIELDS];
    bcd2_t last_v  [N_FIELDS];
    logic  wrap_v  [N_FIELDS];
    logic  step_en [N_FIELDS];
    bcd2_t mon_last;

    assign ld_v[F_SEC]  = ld_sec;
    assign ld_v[F_MIN]  = ld_min;
    assign ld_v[F_HOUR] = ld_hour;
    assign ld_v[F_DOW]  = ld_dow;
    assign ld_v[F_DATE] = ld_date;
    assign ld_v[F_MON]  = ld_month;
    assign ld_v[F_YEAR] = ld_year;
    assign ld_v[F_CENT] = ld_cent;

    // Month length, from the month and year in effect before this step.
    bcd_month_len u_mlen (
        .month     (fld[F_MON]),
        .year      (fld[F_YEAR]),
        .last_date (mon_last)
    );

    // Carry chain: hour wrap feeds both day of week and date.
    always_comb begin
        step_en[F_SEC]  = tick;
        step_en[F_MIN]  = step_en[F_SEC]  & wrap_v[F_SEC];
        step_en[F_HOUR] = step_en[F_MIN]  & wrap_v[F_MIN];
        step_en[F_DOW]  = step_en[F_HOUR] & wrap_v[F_HOUR];
        step_en[F_DATE] = step_en[F_HOUR] & wrap_v[F_HOUR];
        step_en[F_MON]  = step_en[F_DATE] & wrap_v[F_DATE];
        step_en[F_YEAR] = step_en[F_MON]  & wrap_v[F_MON];
        step_en[F_CENT] = step_en[F_YEAR] & wrap_v[F_YEAR];
    end

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
        // The date limit follows the month; every other limit is fixed.
        if (i == F_DATE) begin : g_dyn
            assign last_v[i] = mon_last;
        end else begin : g_fix
            assign last_v[i] = LAST_C[i];
        end

        bcd_step u_step (
            .cur   (fld[i]),
            .last  (last_v[i]),
            .first (FIRST_C[i]),
            .nxt   (nxt_v[i]),
            .wrap  (wrap_v[i])
        );

        // Field register: reset, then load, then step.
        always_ff @(posedge clk) begin
            if (!rst_n)          fld[i] <= INIT_C[i];
            else if (load)       fld[i] <= ld_v[i];
            else if (step_en[i]) fld[i] <= nxt_v[i];
        end
    end

    assign q_sec   = fld[F_SEC];
    assign q_min   = fld[F_MIN];
    assign q_hour  = fld[F_HOUR];
    assign q_dow   = fld[F_DOW];
    assign q_date  = fld[F_DATE];
    assign q_month = fld[F_MON];
    assign q_year  = fld[F_YEAR];
    assign q_cent  = fld[F_CENT];

    // ---------------- assertions ----------------
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> ($stable(q_sec) && $stable(q_min) && $stable(q_hour)
            && $stable(q_dow) && $stable(q_date) && $stable(q_month)
            && $stable(q_year) && $stable(q_cent)));

    p_units_nine_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && q_sec == 8'h09) |=> (q_sec == 8'h10));

    p_min_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && q_sec == 8'h59 && q_min == 8'h14)
            |=> (q_sec == 8'h00 && q_min == 8'h15));

    p_dow_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && q_sec == 8'h59 && q_min == 8'h59 && q_hour == 8'h23
            && q_dow == 8'h07) |=> (q_hour == 8'h00 && q_dow == 8'h01));

    p_april_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && q_sec == 8'h59 && q_min == 8'h59 && q_hour == 8'h23
            && q_month == 8'h04 && q_date == 8'h30)
            |=> (q_date == 8'h01 && q_month == 8'h05));

    p_century_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && q_sec == 8'h59 && q_min == 8'h59 && q_hour == 8'h23
            && q_date == 8'h31 && q_month == 8'h12 && q_year == 8'h99)
            |=> (q_year == 8'h00 && q_month == 8'h01 && q_cent != $past(q_cent)));

    p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q_sec == $past(ld_sec) && q_min == $past(ld_min)
            && q_hour == $past(ld_hour) && q_dow == $past(ld_dow)
            && q_date == $past(ld_date) && q_month == $past(ld_month)
            && q_year == $past(ld_year) && q_cent == $past(ld_cent)));
endmodule

// File: tb/sim_bcd_calendar_counter.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected snapshots, a monitor compares.
module sim_bcd_calendar_counter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic load = 1'b0;
    logic [7:0] ld_sec = '0, ld_min = '0, ld_hour = '0, ld_dow = '0;
    logic [7:0] ld_date = '0, ld_month = '0, ld_year = '0, ld_cent = '0;
    logic [7:0] q_sec, q_min, q_hour, q_dow, q_date, q_month, q_year, q_cent;

    always #10 clk = ~clk;   // 50 MHz

    bcd_calendar_counter u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
        .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_dow(ld_dow),
        .ld_date(ld_date), .ld_month(ld_month), .ld_year(ld_year), .ld_cent(ld_cent),
        .q_sec(q_sec), .q_min(q_min), .q_hour(q_hour), .q_dow(q_dow),
        .q_date(q_date), .q_month(q_month), .q_year(q_year), .q_cent(q_cent)
    );

    typedef struct {
        int          due;
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t q_exp[$];
    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference model state, as plain integers.
    int m_sec, m_min, m_hour, m_dow, m_date, m_mon, m_year, m_cent;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int month_days(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [63:0] snap_model();
        return {to_bcd(m_cent), to_bcd(m_year), to_bcd(m_mon), to_bcd(m_date),
                to_bcd(m_dow), to_bcd(m_hour), to_bcd(m_min), to_bcd(m_sec)};
    endfunction

    task automatic model_tick();
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0; m_hour++;
        if (m_hour < 24) return;
        m_hour = 0;
        m_dow = (m_dow == 7) ? 1 : m_dow + 1;
        m_date++;
        if (m_date <= month_days(m_mon, m_year)) return;
        m_date = 1; m_mon++;
        if (m_mon <= 12) return;
        m_mon = 1; m_year++;
        if (m_year < 100) return;
        m_year = 0;
        m_cent = (m_cent + 1) % 100;
    endtask

    // Drives one cycle of stimulus and queues the expected outputs.
    task automatic drive(input bit t, input bit l, input string tag);
        item_t it;
        @(posedge clk);
        #2;
        tick = t;
        load = l;
        if (l) begin
            m_sec = from_bcd(ld_sec);   m_min = from_bcd(ld_min);
            m_hour = from_bcd(ld_hour); m_dow = from_bcd(ld_dow);
            m_date = from_bcd(ld_date); m_mon = from_bcd(ld_month);
            m_year = from_bcd(ld_year); m_cent = from_bcd(ld_cent);
        end else if (t) begin
            model_tick();
        end
        it.due = cyc + 1;
        it.exp = snap_model();
        it.tag = tag;
        q_exp.push_back(it);
    endtask

    task automatic do_tick(input string tag);
        drive(1'b1, 1'b0, tag);
    endtask

    task automatic do_idle(input string tag);
        drive(1'b0, 1'b0, tag);
    endtask

    // Load with the given values; tick may be asserted too, to test priority.
    task automatic do_load(input int c, input int y, input int mo, input int d,
                           input int w, input int h, input int mi, input int s,
                           input bit with_tick, input string tag);
        ld_cent = to_bcd(c); ld_year = to_bcd(y); ld_month = to_bcd(mo);
        ld_date = to_bcd(d); ld_dow = to_bcd(w);  ld_hour = to_bcd(h);
        ld_min = to_bcd(mi); ld_sec = to_bcd(s);
        drive(with_tick, 1'b1, tag);
    endtask

    // Monitor: compares the outputs with the queued items away from the edge.
    always @(negedge clk) begin
        while (q_exp.size() > 0 && q_exp[0].due == cyc) begin
            item_t it;
            logic [63:0] act;
            it = q_exp.pop_front();
            act = {q_cent, q_year, q_month, q_date, q_dow, q_hour, q_min, q_sec};
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        m_sec = 0; m_min = 0; m_hour = 0; m_dow = 1;
        m_date = 1; m_mon = 1; m_year = 0; m_cent = 20;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        do_idle("R1 reset state");
        do_idle("R2 hold idle");
        do_idle("R2 hold idle");
        for (int i = 0; i < 12; i++) do_tick("R3 seconds count across 09");
        do_idle("R2 hold after ticks");
        do_load(20, 23, 4, 30, 7, 23, 59, 58, 1'b1, "R9 load beats tick");
        do_idle("R2 hold after load");
        do_tick("R3 to 59");
        do_tick("R4 R5 R6 April end, weekday 7 to 1");
        do_load(20, 23, 6, 14, 3, 10, 14, 59, 1'b0, "R9 load");
        do_tick("R4 minute carry");
        do_load(20, 23, 6, 14, 3, 10, 59, 59, 1'b0, "R9 load");
        do_tick("R4 hour carry");
        do_load(20, 23, 2, 28, 2, 23, 59, 59, 1'b0, "R9 load");
        do_tick("R6 R7 Feb 28 common year");
        do_load(20, 24, 2, 28, 3, 23, 59, 59, 1'b0, "R9 load");
        do_tick("R7 Feb 28 leap year");
        do_load(20, 24, 2, 29, 4, 23, 59, 59, 1'b0, "R9 load");
        do_tick("R6 R7 Feb 29 end");
        do_load(21, 0, 2, 28, 5, 23, 59, 59, 1'b0, "R9 load");
        do_tick("R7 year 00 is leap");
        do_load(20, 72, 2, 28, 6, 23, 59, 59, 1'b0, "R9 load");
        do_tick("R7 year 72 is leap");
        do_load(20, 98, 2, 28, 6, 23, 59, 59, 1'b0, "R9 load");
        do_tick("R7 year 98 is common");
        do_load(20, 31, 9, 30, 1, 23, 59, 59, 1'b0, "R9 load");
        do_tick("R6 September end");
        do_load(20, 31, 6, 30, 1, 23, 59, 59, 1'b0, "R9 load");
        do_tick("R6 June end");
        do_load(20, 31, 11, 30, 1, 23, 59, 59, 1'b0, "R9 load");
        do_tick("R6 November end");
        do_load(20, 31, 1, 30, 1, 23, 59, 59, 1'b0, "R9 load");
        do_tick("R6 January 30 is not last");
        do_load(20, 31, 1, 31, 1, 23, 59, 59, 1'b0, "R9 load");
        do_tick("R6 January end");
        do_load(20, 31, 7, 31, 1, 23, 59, 59, 1'b0, "R9 load");
        do_tick("R6 July end");
        do_load(20, 31, 8, 31, 1, 23, 59, 59, 1'b0, "R9 load");
        do_tick("R6 August end");
        do_load(20, 31, 12, 31, 2, 23, 59, 59, 1'b0, "R9 load");
        do_tick("R8 month 12 to 01, year advances");
        do_load(20, 99, 12, 31, 7, 23, 59, 59, 1'b0, "R9 load");
        do_tick("R8 year 99 to 00, century advances");
        do_idle("R2 hold after century");
        for (int i = 0; i < 70; i++) do_tick("R3 R4 free run");
        do_idle("R2 final hold");
        repeat (3) @(posedge clk);
        done = 1;
        finish_run();
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule